// File: doc/BRIEF.md
# Free-running general-purpose timer

The block is an up-counter timer on a simple 32-bit register bus. A reference chosen from a small set of slow clocks is sampled in the bus clock domain. Each rising edge of the chosen reference becomes a one-cycle pulse, and that pulse train is divided by a programmable prescaler. Each output tick of the prescaler advances the counter.

Software programs the control register to pick the source, to pick between wrapping at full scale and returning to zero at a compare value, and to start or stop counting. It reads the running count from its own address. A single status flag records that the counter wrapped past full scale. A self-clearing reset bit in the control register returns every timer register, including the count, to its default value.

Top module: `gp_timer`

## Requirements
- R1: After rst_ni is released: control reads 0, prescaler reads 0, status reads 0, compare reads all ones over CNT_W bits, and the counter reads 0.
- R2: The register offsets are control 0x00, prescaler 0x04, status 0x08, compare 0x10 and counter 0x24. Any other offset reads 0. A read is requested with bus_re_i. Its data appears on bus_rdata_o with bus_rvalid_o high in the cycle after the request, and it shows the register contents as they were before that edge.
- R3: Counting happens only while control bit 0 is 1. While that bit is 0 the counter holds its value.
- R4: Control bits 8:6 select the source. Value 0 gives no ticks. Value 1 gives a tick on every bus cycle. A value k from 2 to 7 counts the rising edges of ref_i[k-2], so value 4 selects ref_i[2]. Edges on references that are not selected have no effect.
- R5: The prescaler register uses its low 12 bits. A value N yields one counter tick per N+1 source pulses, and the register reads back only those 12 bits. The prescaler phase restarts from zero whenever counting is disabled.
- R6: When control bit 9 is 1 (free-run), the counter increments on every tick and wraps from all ones to 0, whatever the compare value.
- R7: When control bit 9 is 0 (restart), a tick that finds the counter equal to the compare register returns the counter to 0.
- R8: Status bit 5 becomes 1 on a tick that finds the counter at all ones. Writing 1 to bit 5 clears it, and writing 0 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R9: Writing 1 to control bit 15 returns control, prescaler, status, compare and counter to their R1 values. Bit 15 reads 1 for SWR_CYC cycles and then clears by itself. Writes made while it reads 1 are ignored.
- R10: The counter register is read-only. A write to offset 0x24 does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all state is in this domain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 6 | Slow reference clocks, sampled asynchronously |
| bus_re_i | input | 1 | Read request |
| bus_we_i | input | 1 | Write request |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_re_i |

## Verification
Two events can fall in the same cycle: the counter wrapping past full scale, which sets the status flag, and a software write of 1 that clears the flag. The bench runs a CNT_W=10 instance with the bus clock as the source. It times the clearing write to the exact edge on which the counter steps from 1023 to 0. It then expects the flag to read 1 and the counter to read 1 once counting stops one cycle later. A separate check makes sure that a clearing write with no wrap present does clear the flag, and that writing 0 does not.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned NUM_REF = (1 << SRC_W) - 2;
  localparam int unsigned PRE_W   = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_STS  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h24;

  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_SRC_LO = 6;
  localparam int unsigned CTRL_FRR    = 9;
  localparam int unsigned CTRL_SWR    = 15;
  localparam int unsigned STS_ROLL    = 5;

  typedef struct packed {
    logic             frr;
    logic [SRC_W-1:0] src;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/gp_timer_tick_gen.sv
module gp_timer_tick_gen
  import gp_timer_pkg::*;
#(
  parameter int unsigned N_REF = NUM_REF,
  parameter int unsigned P_W   = PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REF-1:0] ref_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             en_i,
  input  logic [P_W-1:0]   pre_i,
  input  logic             swr_i,
  output logic             tick_o
);
  localparam int unsigned NSEL = 1 << SRC_W;

  logic [N_REF-1:0] sync1_q, sync2_q, prev_q;
  logic [NSEL-1:0]  sel_pulse;
  logic [P_W-1:0]   pcnt_q;
  logic             raw, pre_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= ref_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign sel_pulse[0] = 1'b0;
  assign sel_pulse[1] = 1'b1;
  for (genvar g = 0; g < N_REF; g++) begin : g_edge
    assign sel_pulse[g+2] = sync2_q[g] & ~prev_q[g];
  end

  assign raw     = sel_pulse[src_i];
  assign pre_hit = (pcnt_q >= pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (swr_i || !en_i)  pcnt_q <= '0;
    else if (raw)             pcnt_q <= pre_hit ? '0 : pcnt_q + 1'b1;
  end

  assign tick_o = en_i & ~swr_i & raw & pre_hit;
endmodule

// File: rtl/gp_timer_counter.sv
module gp_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frr_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             swr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  assign restart = ~frr_i & (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (swr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= restart ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & ~swr_i & (&cnt_q);
endmodule

// File: rtl/gp_timer_regs.sv
module gp_timer_regs
  import gp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SWR_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_re_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              sts_o,
  output logic              swr_act_o
);
  localparam int unsigned SWR_W = $clog2(SWR_CYC + 1);

  ctrl_t             ctrl_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              sts_q;
  logic [SWR_W-1:0]  swr_cnt_q;
  logic              swr_act, swr_start;
  logic              wr_ctrl, wr_pre, wr_sts, wr_cmp;
  logic [BUS_W-1:0]  rd_val, rdata_q;
  logic              rvalid_q;

  assign swr_act   = (swr_cnt_q != '0);
  assign wr_ctrl   = bus_we_i & (bus_addr_i == OFF_CTRL);
  assign wr_pre    = bus_we_i & (bus_addr_i == OFF_PRE);
  assign wr_sts    = bus_we_i & (bus_addr_i == OFF_STS);
  assign wr_cmp    = bus_we_i & (bus_addr_i == OFF_CMP);
  assign swr_start = wr_ctrl & bus_wdata_i[CTRL_SWR] & ~swr_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        swr_cnt_q <= '0;
    else if (swr_start) swr_cnt_q <= SWR_W'(SWR_CYC);
    else if (swr_act)   swr_cnt_q <= swr_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '1;
      sts_q  <= 1'b0;
    end else if (swr_start || swr_act) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '1;
      sts_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en  <= bus_wdata_i[CTRL_EN];
        ctrl_q.src <= bus_wdata_i[CTRL_SRC_LO +: SRC_W];
        ctrl_q.frr <= bus_wdata_i[CTRL_FRR];
      end
      if (wr_pre) pre_q <= bus_wdata_i[PRE_W-1:0];
      if (wr_cmp) cmp_q <= bus_wdata_i[CNT_W-1:0];
      // a wrap in the same cycle beats the clearing write
      if (wrap_i)                                sts_q <= 1'b1;
      else if (wr_sts && bus_wdata_i[STS_ROLL])  sts_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (bus_addr_i)
      OFF_CTRL: begin
        rd_val[CTRL_EN]                = ctrl_q.en;
        rd_val[CTRL_SRC_LO +: SRC_W]   = ctrl_q.src;
        rd_val[CTRL_FRR]               = ctrl_q.frr;
        rd_val[CTRL_SWR]               = swr_act;
      end
      OFF_PRE:  rd_val[PRE_W-1:0] = pre_q;
      OFF_STS:  rd_val[STS_ROLL]  = sts_q;
      OFF_CMP:  rd_val[CNT_W-1:0] = cmp_q;
      OFF_CNT:  rd_val[CNT_W-1:0] = cnt_i;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= bus_re_i ? rd_val : '0;
      rvalid_q <= bus_re_i;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign ctrl_o       = ctrl_q;
  assign pre_o        = pre_q;
  assign cmp_o        = cmp_q;
  assign sts_o        = sts_q;
  assign swr_act_o    = swr_act;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SWR_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REF-1:0] ref_i,
  input  logic               bus_re_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               bus_rvalid_o
);
  ctrl_t            ctrl;
  logic             ctrl_en, ctrl_frr;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cmp, cnt;
  logic             tick, wrap, sts_flag, swr_act;

  assign ctrl_en  = ctrl.en;
  assign ctrl_frr = ctrl.frr;

  gp_timer_regs #(.CNT_W(CNT_W), .SWR_CYC(SWR_CYC)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_re_i    (bus_re_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o),
    .cnt_i       (cnt),
    .wrap_i      (wrap),
    .ctrl_o      (ctrl),
    .pre_o       (pre),
    .cmp_o       (cmp),
    .sts_o       (sts_flag),
    .swr_act_o   (swr_act)
  );

  gp_timer_tick_gen #(.N_REF(NUM_REF), .P_W(PRE_W)) i_tick_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .src_i (ctrl.src),
    .en_i  (ctrl_en),
    .pre_i (pre),
    .swr_i (swr_act),
    .tick_o(tick)
  );

  gp_timer_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .frr_i (ctrl_frr),
    .cmp_i (cmp),
    .swr_i (swr_act),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );
endmodule

module gp_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             en,
  input logic             frr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             wrap,
  input logic             sts,
  input logic             swr_act,
  input logic             re,
  input logic             rvalid
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !swr_act) |=> $stable(cnt)); // R3
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !swr_act && (frr || cnt != cmp)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !swr_act && !frr && cnt == cmp) |=> (cnt == '0)); // R7
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> sts); // R8
  AST_SWR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_act |=> (cnt == '0 && !sts)); // R9
  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re |=> rvalid); // R2
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) i_gp_timer_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .en     (ctrl_en),
  .frr    (ctrl_frr),
  .cnt    (cnt),
  .cmp    (cmp),
  .wrap   (wrap),
  .sts    (sts_flag),
  .swr_act(swr_act),
  .re     (bus_re_i),
  .rvalid (bus_rvalid_o)
);

// File: tb/test_gp_timer.sv
module test_gp_timer;
  import gp_timer_pkg::*;

  localparam int unsigned CNT_W   = 10;
  localparam int unsigned SWR_CYC = 4;
  localparam logic [31:0] CMP_DEF = 32'h3FF;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_REF-1:0] ref_i = '0;
  logic               bus_re_i = 1'b0;
  logic               bus_we_i = 1'b0;
  logic [ADDR_W-1:0]  bus_addr_i = '0;
  logic [BUS_W-1:0]   bus_wdata_i = '0;
  logic [BUS_W-1:0]   bus_rdata_o;
  logic               bus_rvalid_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  gp_timer #(.CNT_W(CNT_W), .SWR_CYC(SWR_CYC)) i_gp_timer (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ref_i       (ref_i),
    .bus_re_i    (bus_re_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o)
  );

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_ni && bus_rvalid_o) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected read data %h, expected no response", bus_rdata_o);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (bus_rdata_o !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata_o, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_re_i = 1'b1; bus_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    bus_re_i = 1'b0;
  endtask

  // enable on one edge, disable exactly k edges later: k ticks at one per cycle
  task automatic run(input logic [31:0] on, input logic [31:0] off, input int k);
    wr(OFF_CTRL, on);
    idle(k - 1);
    wr(OFF_CTRL, off);
  endtask

  task automatic sreset();
    wr(OFF_CTRL, 32'h8000);
    idle(SWR_CYC + 2);
  endtask

  // n rising edges on ref_i[2], 2n rising edges on ref_i[0]
  task automatic ref_burst(input int n);
    for (int i = 0; i < n; i++) begin
      ref_i[2] = 1'b1; ref_i[0] = 1'b1; idle(2);
      ref_i[0] = 1'b0; idle(2);
      ref_i[2] = 1'b0; ref_i[0] = 1'b1; idle(2);
      ref_i[0] = 1'b0; idle(2);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset values, R2 map and unmapped offset
    rd(OFF_CTRL, 32'h0, "R1 ctrl");
    rd(OFF_PRE,  32'h0, "R1 pre");
    rd(OFF_STS,  32'h0, "R1 sts");
    rd(OFF_CMP,  CMP_DEF, "R1 cmp");
    rd(OFF_CNT,  32'h0, "R1 cnt");
    rd(6'h0C,    32'h0, "R2 unmapped");

    // R3 count while enabled, hold while disabled
    run(32'h241, 32'h240, 10);
    rd(OFF_CNT, 32'd10, "R3 count");
    idle(20);
    rd(OFF_CNT, 32'd10, "R3 hold");
    rd(OFF_CTRL, 32'h240, "R2 ctrl readback");

    // R10 counter write ignored
    wr(OFF_CNT, 32'h55);
    rd(OFF_CNT, 32'd10, "R10 read-only");

    // R4 source 0 gives no ticks
    run(32'h201, 32'h200, 10);
    rd(OFF_CNT, 32'd10, "R4 src0");

    // R9 soft reset, self-clear, writes ignored while active
    wr(OFF_PRE, 32'd7);
    wr(OFF_CMP, 32'd9);
    wr(OFF_CTRL, 32'h8000);
    wr(OFF_PRE, 32'd5);
    rd(OFF_CTRL, 32'h8000, "R9 busy bit");
    idle(8);
    rd(OFF_CTRL, 32'h0, "R9 self clear");
    rd(OFF_PRE, 32'h0, "R9 pre default");
    rd(OFF_CMP, CMP_DEF, "R9 cmp default");
    rd(OFF_CNT, 32'h0, "R9 cnt default");

    // R5 prescaler
    wr(OFF_PRE, 32'd3);
    run(32'h241, 32'h240, 10);
    rd(OFF_CNT, 32'd2, "R5 div4");
    sreset();
    wr(OFF_PRE, 32'hFFFF_0001);
    rd(OFF_PRE, 32'h001, "R5 low bits");
    run(32'h241, 32'h240, 10);
    rd(OFF_CNT, 32'd5, "R5 div2");

    // R4 reference selection
    sreset();
    wr(OFF_CTRL, 32'h301);
    ref_burst(5);
    idle(6);
    wr(OFF_CTRL, 32'h300);
    rd(OFF_CNT, 32'd5, "R4 src4 ref2");
    sreset();
    wr(OFF_CTRL, 32'h281);
    ref_burst(5);
    idle(6);
    wr(OFF_CTRL, 32'h280);
    rd(OFF_CNT, 32'd10, "R4 src2 ref0");
    sreset();
    wr(OFF_PRE, 32'd2);
    wr(OFF_CTRL, 32'h301);
    ref_burst(7);
    idle(6);
    wr(OFF_CTRL, 32'h300);
    rd(OFF_CNT, 32'd2, "R5 ref div3");

    // R7 restart at compare, R6 free-run ignores compare
    sreset();
    wr(OFF_CMP, 32'd5);
    run(32'h041, 32'h040, 13);
    rd(OFF_CNT, 32'd1, "R7 restart");
    sreset();
    wr(OFF_CMP, 32'd5);
    run(32'h241, 32'h240, 13);
    rd(OFF_CNT, 32'd13, "R6 free-run past cmp");

    // R6 wrap, R8 flag and write-one-to-clear
    sreset();
    run(32'h241, 32'h240, 1030);
    rd(OFF_CNT, 32'd6, "R6 wrap");
    rd(OFF_STS, 32'h20, "R8 flag set");
    wr(OFF_STS, 32'h0);
    rd(OFF_STS, 32'h20, "R8 write0 keeps");
    wr(OFF_STS, 32'h20);
    rd(OFF_STS, 32'h0, "R8 write1 clears");

    // R8 wrap and clear on the same edge: set wins
    sreset();
    wr(OFF_CTRL, 32'h241);
    idle(1023);
    wr(OFF_STS, 32'h20);
    wr(OFF_CTRL, 32'h240);
    rd(OFF_STS, 32'h20, "R8 set wins");
    rd(OFF_CNT, 32'd1, "R6 count after collision");

    idle(4);
    if (sb.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL R2: %0d reads unanswered, expected 0", sb.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule